// File: doc/BRIEF.md
# Watermark UART Register Block

This block is the register side of a memory-mapped serial port. A CPU reaches it over a simple 32-bit register bus. Through that bus it can send one character at a time, drain an 8-deep receive FIFO, program transmit and receive watermark counts, enable interrupts and store a baud divisor. The bit-level serializer, the deserializer and the baud generator sit outside the block. Characters arrive here already assembled, on a byte-wide input with a valid/ready pair. Each character written for transmission leaves on a byte-wide output with a one-cycle valid strobe. The divisor is only stored and read back.

A single level interrupt line is formed from the interrupt-enable register and the receive FIFO fill. The interrupt-pending register is read-only. Its bits are found by comparing the FIFO fill and the watermark fields against each other. A read of the receive data register on an empty FIFO returns a flag in bit 31 instead of data, so software can poll without reading the pending register first.

Top module: `wm_uart_regs`

## Requirements
- R1: After reset, every register reads zero, the receive data register reads 0x80000000, the interrupt output is low and the receive input is ready.
- R2: An access counts only when `bus_size` is 2'b10 (a full word). Any other size reads zero, writes nothing, sends no character and removes no FIFO byte.
- R3: A word read of the receive data register (offset 0x04) on a non-empty FIFO returns the oldest byte in bits 7:0, with zeros above, and removes that byte.
- R4: A word read of the receive data register on an empty FIFO returns 0x80000000 and leaves the FIFO unchanged.
- R5: A word write to the transmit data register (offset 0x00) raises `tx_valid` for exactly the following cycle, with `tx_data` equal to bits 7:0 of the written word. A read of that offset returns zero.
- R6: Bit 1 of the pending register (offset 0x14) is 1 exactly when the FIFO fill is strictly greater than bits 18:16 of the receive control register (offset 0x0C).
- R7: Bit 0 of the pending register is 1 exactly when bits 18:16 of the transmit control register (offset 0x08) are nonzero. All other pending bits read zero.
- R8: `irq` is high when bit 0 of the interrupt-enable register (offset 0x10) is set, or when its bit 1 is set and the FIFO is not empty. Otherwise `irq` is low.
- R9: The receive FIFO holds 8 bytes. While it is full, `rx_ready` is low and a byte offered on `rx_data` is dropped.
- R10: The interrupt-enable register, both control registers and the divisor register (offset 0x18) read back all 32 bits last written. Writes to the pending register are ignored. Unmapped offsets read zero and ignore writes.
- R11: A byte pushed in the same cycle as a receive data read is kept, and is queued behind the bytes already held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size; only 2'b10 (word) is accepted |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| rx_data | input | 8 | Received character |
| rx_valid | input | 1 | Received character present |
| rx_ready | output | 1 | FIFO can accept a character |
| tx_data | output | 8 | Character to transmit |
| tx_valid | output | 1 | One-cycle strobe for `tx_data` |
| irq | output | 1 | Level interrupt |

## Verification
The assertions check several things on every cycle:
- the FIFO fill stays within its depth;
- `rx_ready` is low whenever the FIFO is full;
- a pop, with or without a push in the same cycle, changes the fill by the right amount;
- a read of an empty FIFO leaves the fill unchanged;
- a transmit strobe never appears without a word write one cycle before;
- a badly sized access never produces a strobe;
- `irq` stays low while both enables are clear.

Only the bench's scenarios can show the data values:
- that bytes come out in arrival order;
- the exact boundary of the receive watermark comparison;
- the full-width readback of each register;
- that the ninth byte is really lost;
- that writes to the pending register and to unmapped offsets leave no trace.

// File: rtl/wm_uart_pkg.sv
package wm_uart_pkg;
  localparam int OFF_TXDATA = 'h00;
  localparam int OFF_RXDATA = 'h04;
  localparam int OFF_TXCTRL = 'h08;
  localparam int OFF_RXCTRL = 'h0C;
  localparam int OFF_IEN    = 'h10;
  localparam int OFF_IPEND  = 'h14;
  localparam int OFF_DIVISR = 'h18;

  localparam logic [1:0] SIZE_WORD = 2'b10;
  localparam int WM_LO = 16;
  localparam int WM_W  = 3;
  localparam int IRQ_TX = 0;
  localparam int IRQ_RX = 1;
  localparam logic [31:0] RX_EMPTY_WORD = 32'h8000_0000;

  // watermark count field of a control register
  function automatic logic [WM_W-1:0] wm_field(input logic [31:0] ctrl);
    return ctrl[WM_LO +: WM_W];
  endfunction

  // receive watermark: fill strictly above the programmed count
  function automatic logic rx_over(input int unsigned fill, input int unsigned lim);
    return fill > lim;
  endfunction

  function automatic logic irq_level(input logic en_tx, input logic en_rx, input logic nonempty);
    return en_tx | (en_rx & nonempty);
  endfunction
endpackage

// File: rtl/wm_rx_fifo.sv
module wm_rx_fifo #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [DW-1:0]    din,
  output logic [DW-1:0]    dout,
  output logic [CNT_W-1:0] cnt,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign dout  = mem[rp];
  assign full  = (cnt == CNT_W'(DEPTH));
  assign empty = (cnt == '0);
endmodule

// File: rtl/wm_irq_logic.sv
module wm_irq_logic
  import wm_uart_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic [31:0]      txctrl,
  input  logic [31:0]      rxctrl,
  input  logic [1:0]       ien,
  input  logic [CNT_W-1:0] fill,
  output logic [31:0]      pend,
  output logic             irq
);
  logic tx_wm, rx_wm;

  always_comb begin
    tx_wm = (wm_field(txctrl) != '0);
    rx_wm = rx_over(32'(fill), 32'(wm_field(rxctrl)));
    pend = '0;
    pend[IRQ_TX] = tx_wm;
    pend[IRQ_RX] = rx_wm;
    irq = irq_level(ien[IRQ_TX], ien[IRQ_RX], fill != '0);
  end
endmodule

// File: rtl/wm_uart_regs.sv
module wm_uart_regs
  import wm_uart_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int RX_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [7:0]        rx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  output logic              irq
);
  localparam int CNT_W = $clog2(RX_DEPTH + 1);

  logic [31:0] ien_q, txc_q, rxc_q, div_q, pend;
  logic [CNT_W-1:0] fifo_cnt;
  logic [7:0] fifo_dout;
  logic fifo_full, fifo_empty;

  // named events for the checker
  logic acc_ok, rd_ev, wr_ev;
  logic push_ev, pop_ev, tx_wr_ev, rx_rd_ev;

  assign acc_ok   = bus_sel && (bus_size == SIZE_WORD);
  assign rd_ev    = acc_ok && !bus_wr;
  assign wr_ev    = acc_ok && bus_wr;
  assign rx_rd_ev = rd_ev && (bus_addr == ADDR_W'(OFF_RXDATA));
  assign pop_ev   = rx_rd_ev && !fifo_empty;
  assign push_ev  = rx_valid && !fifo_full;
  assign tx_wr_ev = wr_ev && (bus_addr == ADDR_W'(OFF_TXDATA));
  assign rx_ready = !fifo_full;

  wm_rx_fifo #(.DEPTH(RX_DEPTH), .DW(8), .CNT_W(CNT_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push_ev),
    .pop   (pop_ev),
    .din   (rx_data),
    .dout  (fifo_dout),
    .cnt   (fifo_cnt),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  wm_irq_logic #(.CNT_W(CNT_W)) u_irq (
    .txctrl (txc_q),
    .rxctrl (rxc_q),
    .ien    (ien_q[1:0]),
    .fill   (fifo_cnt),
    .pend   (pend),
    .irq    (irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien_q    <= '0;
      txc_q    <= '0;
      rxc_q    <= '0;
      div_q    <= '0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      tx_valid <= tx_wr_ev;
      if (tx_wr_ev) tx_data <= bus_wdata[7:0];
      if (wr_ev) begin
        if (bus_addr == ADDR_W'(OFF_TXCTRL)) txc_q <= bus_wdata;
        if (bus_addr == ADDR_W'(OFF_RXCTRL)) rxc_q <= bus_wdata;
        if (bus_addr == ADDR_W'(OFF_IEN))    ien_q <= bus_wdata;
        if (bus_addr == ADDR_W'(OFF_DIVISR)) div_q <= bus_wdata;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_ev) begin
      if (bus_addr == ADDR_W'(OFF_RXDATA))
        bus_rdata = fifo_empty ? RX_EMPTY_WORD : {24'b0, fifo_dout};
      else if (bus_addr == ADDR_W'(OFF_TXCTRL)) bus_rdata = txc_q;
      else if (bus_addr == ADDR_W'(OFF_RXCTRL)) bus_rdata = rxc_q;
      else if (bus_addr == ADDR_W'(OFF_IEN))    bus_rdata = ien_q;
      else if (bus_addr == ADDR_W'(OFF_IPEND))  bus_rdata = pend;
      else if (bus_addr == ADDR_W'(OFF_DIVISR)) bus_rdata = div_q;
    end
  end
endmodule

// File: rtl/wm_uart_checks.sv
module wm_uart_checks #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic [1:0]       bus_size,
  input logic [CNT_W-1:0] fifo_cnt,
  input logic             push_ev,
  input logic             pop_ev,
  input logic             rx_rd_ev,
  input logic             tx_wr_ev,
  input logic             tx_valid,
  input logic             rx_ready,
  input logic [31:0]      ien_q,
  input logic             irq
);
  a_r9_fill_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CNT_W'(DEPTH));

  a_r9_not_ready_full: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_cnt == CNT_W'(DEPTH)) |-> !rx_ready);

  a_r3_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ev && !push_ev) |=> (fifo_cnt == $past(fifo_cnt) - 1'b1));

  a_r11_push_pop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ev && push_ev) |=> (fifo_cnt == $past(fifo_cnt)));

  a_r4_empty_read_still: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd_ev && fifo_cnt == '0 && !push_ev) |=> (fifo_cnt == '0));

  a_r5_strobe_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(tx_wr_ev));

  a_r2_bad_size_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_size != 2'b10) |=> !tx_valid);

  a_r8_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q[1:0] == 2'b00) |-> !irq);
endmodule

bind wm_uart_regs wm_uart_checks #(.DEPTH(RX_DEPTH), .CNT_W(CNT_W)) u_checks (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_sel  (bus_sel),
  .bus_size (bus_size),
  .fifo_cnt (fifo_cnt),
  .push_ev  (push_ev),
  .pop_ev   (pop_ev),
  .rx_rd_ev (rx_rd_ev),
  .tx_wr_ev (tx_wr_ev),
  .tx_valid (tx_valid),
  .rx_ready (rx_ready),
  .ien_q    (ien_q),
  .irq      (irq)
);

// File: tb/wm_uart_regs_test.sv
module wm_uart_regs_test;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 8;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [1:0] bus_size = 2'b10;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [7:0] rx_data = 0, tx_data;
  logic rx_valid = 0, rx_ready, tx_valid, irq;

  int total = 0, bad = 0;
  bit in_reset_phase = 0;
  logic [31:0] last_rd;

  // reference model
  byte unsigned q[$];
  logic [31:0] m_ien = 0, m_txc = 0, m_rxc = 0, m_div = 0;
  bit exp_txv = 0;
  logic [7:0] exp_txd = 0;

  wm_uart_regs uut (.*);

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [7:0] a);
    logic [31:0] p;
    case (a)
      8'h04: return (q.size() == 0) ? 32'h8000_0000 : {24'b0, q[0]};
      8'h08: return m_txc;
      8'h0C: return m_rxc;
      8'h10: return m_ien;
      8'h14: begin
        p = 0;
        p[0] = (m_txc[18:16] != 0);
        p[1] = (q.size() > int'(m_rxc[18:16]));
        return p;
      end
      8'h18: return m_div;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_for(input logic [7:0] a, input bit okz);
    if (in_reset_phase) return "R1";
    if (!okz) return "R2";
    case (a)
      8'h00: return "R5";
      8'h04: return (q.size() == 0) ? "R4" : "R3";
      8'h14: return "R6";
      default: return "R10";
    endcase
  endfunction

  // one bus/rx cycle, entered and left at a falling edge
  task automatic step(input bit s, input bit w, input logic [1:0] sz, input logic [7:0] a,
                      input logic [31:0] d, input bit rv, input logic [7:0] rd);
    bit okz, do_pop, do_push;
    logic [31:0] er;
    bus_sel = s; bus_wr = w; bus_size = sz; bus_addr = a; bus_wdata = d;
    rx_valid = rv; rx_data = rd;
    #1;
    okz = (sz == 2'b10);
    er = (s && !w && okz) ? model_read(a) : 32'h0;
    last_rd = bus_rdata;
    if (s && !w) begin
      if (okz && a == 8'h14) begin
        check(bus_rdata[1] == er[1], "R6", bus_rdata, er);
        check(bus_rdata[31:2] == 0 && bus_rdata[0] == er[0], "R7", bus_rdata, er);
      end else
        check(bus_rdata == er, tag_for(a, okz), bus_rdata, er);
    end
    check(irq == (m_ien[0] | (m_ien[1] & (q.size() != 0))), "R8", {31'b0, irq}, 32'(m_ien[0] | (m_ien[1] & (q.size() != 0))));
    check(rx_ready == (q.size() < DEPTH), "R9", {31'b0, rx_ready}, 32'(q.size() < DEPTH));
    do_pop  = s && !w && okz && a == 8'h04 && q.size() != 0;
    do_push = rv && q.size() < DEPTH;
    @(posedge clk);
    exp_txv = s && w && okz && a == 8'h00;
    if (exp_txv) exp_txd = d[7:0];
    if (s && w && okz) begin
      if (a == 8'h08) m_txc = d;
      if (a == 8'h0C) m_rxc = d;
      if (a == 8'h10) m_ien = d;
      if (a == 8'h18) m_div = d;
    end
    if (do_pop) void'(q.pop_front());
    if (do_push) q.push_back(rd);
    @(negedge clk);
    check(tx_valid == exp_txv, okz ? "R5" : "R2", {31'b0, tx_valid}, {31'b0, exp_txv});
    if (exp_txv) check(tx_data == exp_txd, "R5", {24'b0, tx_data}, {24'b0, exp_txd});
    bus_sel = 0; rx_valid = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d); step(1, 1, 2'b10, a, d, 0, 0); endtask
  task automatic rd(input logic [7:0] a); step(1, 0, 2'b10, a, 0, 0, 0); endtask
  task automatic push(input logic [7:0] b); step(0, 0, 2'b10, 0, 0, 1, b); endtask

  initial begin : watchdog
    #(PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    in_reset_phase = 1;
    for (int a = 0; a < 8'h20; a += 4) rd(8'(a));
    in_reset_phase = 0;
    // R10: readback, pending write ignored, unmapped
    wr(8'h08, 32'hDEAD_BEEF); rd(8'h08);
    wr(8'h0C, 32'h1234_5678); rd(8'h0C);
    wr(8'h18, 32'hCAFE_F00D); rd(8'h18);
    wr(8'h10, 32'hFFFF_FFFC); rd(8'h10);
    wr(8'h14, 32'hFFFF_FFFF); rd(8'h14);
    wr(8'h1C, 32'h5555_5555); rd(8'h1C);
    wr(8'h40, 32'h5555_5555); rd(8'h40);
    rd(8'h02);
    // R5: transmit
    wr(8'h00, 32'h1234_56C3); rd(8'h00);
    wr(8'h00, 32'h0000_007E); wr(8'h00, 32'hFFFF_FF01);
    // R7: transmit watermark field
    wr(8'h08, 32'h0001_0000); rd(8'h14);
    wr(8'h08, 32'hFFF8_FFFF); rd(8'h14);
    // R6: receive watermark boundary with count 2
    wr(8'h0C, 32'h0002_0000);
    push(8'hA1); rd(8'h14); push(8'hA2); rd(8'h14); push(8'hA3); rd(8'h14);
    // R8: interrupt enables
    wr(8'h10, 32'h2); rd(8'h10); wr(8'h10, 32'h1); wr(8'h10, 32'h0); push(8'hA4);
    // R2: bad sizes do nothing
    step(1, 0, 2'b01, 8'h04, 0, 0, 0);
    step(1, 1, 2'b00, 8'h10, 32'h3, 0, 0);
    step(1, 1, 2'b11, 8'h00, 32'h99, 0, 0);
    rd(8'h10);
    // R9: fill, overflow dropped
    for (int i = 0; i < 6; i++) push(8'hB0 + 8'(i));
    wr(8'h10, 32'h2);
    // R3: drain in order
    for (int i = 0; i < DEPTH; i++) rd(8'h04);
    rd(8'h04); // R4
    rd(8'h04);
    wr(8'h10, 32'h0);
    // R11: push during read
    push(8'h11); push(8'h22);
    step(1, 0, 2'b10, 8'h04, 0, 1, 8'h33);
    check(last_rd == 32'h11, "R11", last_rd, 32'h11);
    rd(8'h04); check(last_rd == 32'h22, "R11", last_rd, 32'h22);
    rd(8'h04); check(last_rd == 32'h33, "R11", last_rd, 32'h33);
    rd(8'h04); check(last_rd == 32'h8000_0000, "R4", last_rd, 32'h8000_0000);
    // R1: reset mid-operation
    push(8'h55); wr(8'h10, 32'h3); wr(8'h18, 32'h7);
    rst_n = 0; @(negedge clk); rst_n = 1;
    q.delete(); m_ien = 0; m_txc = 0; m_rxc = 0; m_div = 0;
    in_reset_phase = 1;
    rd(8'h04); rd(8'h10); rd(8'h18); rd(8'h08); rd(8'h0C); rd(8'h14);
    in_reset_phase = 0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule